// File: doc/BRIEF.md
# Bulk IN Endpoint Control and Status Register

This block is the control and status word that software uses to drive one USB device Bulk IN endpoint. It also keeps the packet-ready bookkeeping that sits beside that endpoint's transmit FIFO. Software reaches it through address-decoded read and write strobes that carry 32-bit data. The packet engine reaches it through single-cycle event pulses and a few level outputs.

The block counts the bytes loaded into the transmit FIFO. A full packet becomes ready when the count reaches the maximum packet size. A shorter packet, including an empty one, becomes ready when software writes the short-packet commit bit. A sent-packet event removes the transmitted bytes from the count and ends any pending commit. A flush request empties the count and cancels the commit. Sticky flags record when a packet has gone out, when the FIFO ran dry and when a STALL handshake was sent. A plain control bit makes the endpoint answer IN tokens with STALL.

Top module: `bin_ep_csr`

## Requirements
- R1: After reset the status word reads 0x0000_0001, and pkt_ready, flush_req and stall_force are all 0.
- R2: Bit 0 is read-only. It reads 1 only when the free space (64 bytes less the occupancy) is at least 64 bytes and no short commit is pending. Otherwise it reads 0.
- R3: Bit 1 (packet done) is set by pkt_sent and cleared by writing 1 to it. Writing 0 leaves it unchanged.
- R4: Bit 3 (underrun) is set by underrun_evt and stays set across idle cycles until software writes 1 to it. Writing 0 leaves it unchanged.
- R5: Bit 4 (stall sent) is set by stall_evt and cleared by writing 1 to it. Writing 0 leaves it unchanged.
- R6: When a hardware set event and a software write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R7: Bit 5 is read/write and takes the value written on every write. stall_force equals it.
- R8: Writing 1 to bit 2 has these effects: flush_req is high for exactly the one cycle after the write, the occupancy becomes 0, and a pending commit is cancelled. The sticky flags keep their values, and bit 2 reads 0.
- R9: Writing 1 to bit 7 makes pkt_ready high from the next cycle, even with zero bytes loaded. Bit 7 reads 0. The next pkt_sent ends the commit.
- R10: pkt_ready goes high when the occupancy reaches 64 bytes. A push while the FIFO holds 64 bytes is ignored.
- R11: pkt_sent subtracts sent_bytes from the occupancy, clamped at 0.
- R12: Bit 6 and bits 31:8 always read 0. reg_rdata is 0 whenever reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, already address-decoded for this register |
| reg_rd | input | 1 | Read strobe, already address-decoded for this register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, 0 when reg_rd is low |
| push | input | 1 | One byte loaded into the transmit FIFO |
| pkt_sent | input | 1 | Packet transmitted successfully |
| sent_bytes | input | 7 | Byte count of the transmitted packet, valid with pkt_sent |
| underrun_evt | input | 1 | Transmit FIFO underrun event |
| stall_evt | input | 1 | STALL handshake sent event |
| flush_req | output | 1 | One-cycle request to empty the FIFO storage |
| pkt_ready | output | 1 | A full or committed short packet is waiting |
| stall_force | output | 1 | Answer IN tokens with STALL |

## Verification
The assertions assume three things about the inputs: event inputs are single-cycle pulses, sent_bytes matters only while pkt_sent is high, and a write strobe lasts one cycle. The stimulus meets these assumptions. Every pulse and write is driven for exactly one cycle and released at the next falling edge. Pushes are issued one byte per cycle. Short commits are used only for packets below 64 bytes. The only overlaps the stimulus creates on purpose are a set event together with its clear, and a push while the FIFO is full; both are tested deliberately.

// File: rtl/bin_ep_pkg.sv
package bin_ep_pkg;

  // Field positions inside the status word.
  localparam int unsigned BIT_SPACE   = 0;
  localparam int unsigned BIT_DONE    = 1;
  localparam int unsigned BIT_FLUSH   = 2;
  localparam int unsigned BIT_UNDR    = 3;
  localparam int unsigned BIT_STALLED = 4;
  localparam int unsigned BIT_FSTALL  = 5;
  localparam int unsigned BIT_SHORT   = 7;

  // Index of each sticky flag in the flag bank.
  localparam int unsigned NFLAGS      = 3;
  localparam int unsigned FLG_DONE    = 0;
  localparam int unsigned FLG_UNDR    = 1;
  localparam int unsigned FLG_STALLED = 2;

  typedef struct packed {
    logic short_go;
    logic fstall_we;
    logic fstall_val;
    logic stalled_clr;
    logic undr_clr;
    logic flush_go;
    logic done_clr;
  } ctl_wr_t;

  function automatic ctl_wr_t decode_wr(input logic we, input logic [31:0] d);
    ctl_wr_t c;
    c.short_go    = we & d[BIT_SHORT];
    c.fstall_we   = we;
    c.fstall_val  = d[BIT_FSTALL];
    c.stalled_clr = we & d[BIT_STALLED];
    c.undr_clr    = we & d[BIT_UNDR];
    c.flush_go    = we & d[BIT_FLUSH];
    c.done_clr    = we & d[BIT_DONE];
    return c;
  endfunction

endpackage

// File: rtl/bin_ep_regif.sv
module bin_ep_regif
  import bin_ep_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              space_i,
  input  logic [NFLAGS-1:0] flags_i,
  input  logic              fstall_i,
  output ctl_wr_t           ctl_o,
  output logic [DW-1:0]     reg_rdata
);

  logic [DW-1:0] word;
  logic          unused_wbits;

  // Bit 0 (read-only), bit 6 and everything above bit 7 carry nothing on a write.
  assign unused_wbits = ^{reg_wdata[DW-1:8], reg_wdata[6], reg_wdata[0]};

  assign ctl_o = decode_wr(reg_wr, reg_wdata[31:0]);

  always_comb begin
    word                = '0;
    word[BIT_SPACE]     = space_i;
    word[BIT_DONE]      = flags_i[FLG_DONE];
    word[BIT_UNDR]      = flags_i[FLG_UNDR];
    word[BIT_STALLED]   = flags_i[FLG_STALLED];
    word[BIT_FSTALL]    = fstall_i;
    // The flush and short-commit strobes always read back as zero.
  end

  assign reg_rdata = reg_rd ? word : '0;

endmodule

// File: rtl/bin_ep_flags.sv
module bin_ep_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;

    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end

    assign q_o[g] = q;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> q_o[g]);

    // R3 R4 R5
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !q_o[g]);

    // R3 R4 R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !set_i[g]) |=> $stable(q_o[g]));
  end

endmodule

// File: rtl/bin_ep_occ.sv
module bin_ep_occ #(
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned MAX_PKT    = 64,
  localparam int unsigned CW = $clog2(FIFO_BYTES + 1),
  localparam int unsigned SW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          sent_i,
  input  logic [SW-1:0] sent_bytes_i,
  input  logic          flush_i,
  input  logic          commit_i,
  output logic          ready_o,
  output logic          space_o
);

  logic [CW-1:0] count;
  logic          pend;
  logic [SW-1:0] take;

  // One cycle of occupancy: the bytes sent leave first (never below zero), then a push is
  // accepted only if the FIFO was not already full.
  function automatic logic [CW-1:0] occ_step(input logic [CW-1:0] cur,
                                             input logic          add,
                                             input logic [SW-1:0] sub);
    logic [CW:0] t;
    logic [CW:0] tk;
    tk = (CW+1)'(sub);
    if (tk > {1'b0, cur}) tk = {1'b0, cur};
    t = {1'b0, cur} - tk;
    if (add && (cur < CW'(FIFO_BYTES))) t = t + (CW+1)'(1);
    return t[CW-1:0];
  endfunction

  function automatic logic has_room(input logic [CW-1:0] cur, input logic p);
    logic [CW-1:0] free;
    free = CW'(FIFO_BYTES) - cur;
    return (free >= CW'(MAX_PKT)) && !p;
  endfunction

  assign take = sent_i ? sent_bytes_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (flush_i) count <= '0;
    else              count <= occ_step(count, push_i, take);
  end

  // A commit write wins over a send in the same cycle; a flush cancels both.
  always_ff @(posedge clk) begin
    if (!rst_n)        pend <= 1'b0;
    else if (flush_i)  pend <= 1'b0;
    else if (commit_i) pend <= 1'b1;
    else if (sent_i)   pend <= 1'b0;
  end

  assign ready_o = (count >= CW'(MAX_PKT)) || pend;
  assign space_o = has_room(count, pend);

  // R10
  occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(FIFO_BYTES));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (count == '0) && !ready_o);

  // R9
  commit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !flush_i) |=> ready_o);

  // R11
  sent_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_i && !push_i && !flush_i && !commit_i && (CW'(sent_bytes_i) >= count))
      |=> (count == '0) && space_o);

endmodule

// File: rtl/bin_ep_csr.sv
module bin_ep_csr
  import bin_ep_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned MAX_PKT    = 64,
  parameter int unsigned DW         = 32,
  localparam int unsigned SW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          push,
  input  logic          pkt_sent,
  input  logic [SW-1:0] sent_bytes,
  input  logic          underrun_evt,
  input  logic          stall_evt,
  output logic          flush_req,
  output logic          pkt_ready,
  output logic          stall_force
);

  ctl_wr_t           ctl;
  logic [NFLAGS-1:0] flag_set;
  logic [NFLAGS-1:0] flag_clr;
  logic [NFLAGS-1:0] flags;
  logic              space;
  logic              fstall_q;
  logic              flush_q;

  bin_ep_regif #(.DW(DW)) regif_i (
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .space_i   (space),
    .flags_i   (flags),
    .fstall_i  (fstall_q),
    .ctl_o     (ctl),
    .reg_rdata (reg_rdata)
  );

  always_comb begin
    flag_set              = '0;
    flag_clr              = '0;
    flag_set[FLG_DONE]    = pkt_sent;
    flag_set[FLG_UNDR]    = underrun_evt;
    flag_set[FLG_STALLED] = stall_evt;
    flag_clr[FLG_DONE]    = ctl.done_clr;
    flag_clr[FLG_UNDR]    = ctl.undr_clr;
    flag_clr[FLG_STALLED] = ctl.stalled_clr;
  end

  bin_ep_flags #(.N(NFLAGS)) flags_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flags)
  );

  bin_ep_occ #(.FIFO_BYTES(FIFO_BYTES), .MAX_PKT(MAX_PKT)) occ_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push),
    .sent_i       (pkt_sent),
    .sent_bytes_i (sent_bytes),
    .flush_i      (ctl.flush_go),
    .commit_i     (ctl.short_go),
    .ready_o      (pkt_ready),
    .space_o      (space)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             fstall_q <= 1'b0;
    else if (ctl.fstall_we) fstall_q <= ctl.fstall_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= ctl.flush_go;
  end

  assign stall_force = fstall_q;
  assign flush_req   = flush_q;

  // R8
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[BIT_FLUSH]) |=> flush_req);

  // R7
  stall_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (stall_force == $past(reg_wdata[BIT_FSTALL])));

  // R12
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0));

endmodule

// File: tb/bin_ep_csr_tb_top.sv
module bin_ep_csr_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        push = 1'b0;
  logic        pkt_sent = 1'b0;
  logic [6:0]  sent_bytes = '0;
  logic        underrun_evt = 1'b0;
  logic        stall_evt = 1'b0;
  logic        flush_req;
  logic        pkt_ready;
  logic        stall_force;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bin_ep_csr dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push(push),
    .pkt_sent(pkt_sent), .sent_bytes(sent_bytes),
    .underrun_evt(underrun_evt), .stall_evt(stall_evt),
    .flush_req(flush_req), .pkt_ready(pkt_ready), .stall_force(stall_force)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(output logic [31:0] d);
    reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      push = 1'b1;
      tick();
    end
    push = 1'b0;
  endtask

  task automatic send(input int n);
    pkt_sent = 1'b1; sent_bytes = 7'(n);
    tick();
    pkt_sent = 1'b0; sent_bytes = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(v);
    check("R1 reset word", v, 32'h1);
    check("R1 reset pkt_ready", {31'b0, pkt_ready}, 32'h0);
    check("R1 reset flush_req", {31'b0, flush_req}, 32'h0);
    check("R1 reset stall_force", {31'b0, stall_force}, 32'h0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    push_n(63);
    check("R10 not ready at 63", {31'b0, pkt_ready}, 32'h0);
    push_n(1);
    check("R10 ready at 64", {31'b0, pkt_ready}, 32'h1);
    rd(v);
    check("R2 no space when full", v, 32'h0);
    push_n(2);
    send(64);
    check("R11 ready drops after send", {31'b0, pkt_ready}, 32'h0);
    rd(v);
    check("R10 R3 extra pushes ignored, done set", v, 32'h3);
  endtask

  task automatic t_done_w1c();
    logic [31:0] v;
    wr(32'h0);
    rd(v);
    check("R3 write 0 keeps done", v, 32'h3);
    wr(32'h2);
    rd(v);
    check("R3 write 1 clears done", v, 32'h1);
  endtask

  task automatic t_short();
    logic [31:0] v;
    push_n(5);
    check("R9 five bytes not ready", {31'b0, pkt_ready}, 32'h0);
    rd(v);
    check("R2 partial fill no space", v, 32'h0);
    wr(32'h80);
    check("R9 commit makes ready", {31'b0, pkt_ready}, 32'h1);
    rd(v);
    check("R9 commit bit reads 0", v, 32'h0);
    send(5);
    check("R9 send ends commit", {31'b0, pkt_ready}, 32'h0);
    rd(v);
    check("R11 R2 short sent, space back", v, 32'h3);
    wr(32'h2);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(32'h80);
    check("R9 zero-length commit ready", {31'b0, pkt_ready}, 32'h1);
    rd(v);
    check("R2 pending commit clears space", v, 32'h0);
    send(0);
    check("R9 zero-length sent", {31'b0, pkt_ready}, 32'h0);
    rd(v);
    check("R9 zero-length done", v, 32'h3);
    wr(32'h2);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    push_n(64);
    send(20);
    check("R11 44 left not ready", {31'b0, pkt_ready}, 32'h0);
    push_n(19);
    check("R11 63 after refill not ready", {31'b0, pkt_ready}, 32'h0);
    push_n(1);
    check("R11 refill to 64 ready", {31'b0, pkt_ready}, 32'h1);
    send(64);
    wr(32'h2);
    push_n(3);
    send(10);
    rd(v);
    check("R11 oversize send clamps to 0", v, 32'h3);
    wr(32'h2);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    underrun_evt = 1'b1; tick(); underrun_evt = 1'b0;
    tick();
    rd(v);
    check("R4 underrun sticky", v, 32'h9);
    stall_evt = 1'b1; tick(); stall_evt = 1'b0;
    rd(v);
    check("R5 stall sent set", v, 32'h19);
    wr(32'h0);
    rd(v);
    check("R4 R5 write 0 no effect", v, 32'h19);
    wr(32'h8);
    rd(v);
    check("R4 underrun W1C", v, 32'h11);
    wr(32'h10);
    rd(v);
    check("R5 stall sent W1C", v, 32'h1);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    underrun_evt = 1'b1;
    wr(32'h8);
    underrun_evt = 1'b0;
    rd(v);
    check("R6 underrun set beats clear", v, 32'h9);
    wr(32'h8);
    pkt_sent = 1'b1; sent_bytes = '0;
    wr(32'h2);
    pkt_sent = 1'b0;
    rd(v);
    check("R6 done set beats clear", v, 32'h3);
    wr(32'h2);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    wr(32'h20);
    check("R7 stall_force high", {31'b0, stall_force}, 32'h1);
    rd(v);
    check("R7 bit 5 reads 1", v, 32'h21);
    wr(32'h0);
    check("R7 stall_force low", {31'b0, stall_force}, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    underrun_evt = 1'b1; tick(); underrun_evt = 1'b0;
    push_n(10);
    wr(32'h80);
    check("R9 ready before flush", {31'b0, pkt_ready}, 32'h1);
    wr(32'h4);
    check("R8 flush_req pulse", {31'b0, flush_req}, 32'h1);
    check("R8 flush cancels ready", {31'b0, pkt_ready}, 32'h0);
    rd(v);
    check("R8 flags kept, space back, bit2 reads 0", v, 32'h9);
    tick();
    check("R8 flush_req one cycle", {31'b0, flush_req}, 32'h0);
    wr(32'h8);
  endtask

  task automatic t_rsvd();
    logic [31:0] v;
    wr(32'hFFFF_FF40);
    rd(v);
    check("R12 reserved read 0", v, 32'h1);
    #1;
    check("R12 rdata 0 without read", reg_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_done_w1c();
    t_short();
    t_zero();
    t_partial();
    t_sticky();
    t_prio();
    t_stall();
    t_flush();
    t_rsvd();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule